// File: doc/BRIEF.md
# Block Copy Engine for Video Memory

This engine copies data from anywhere in a 16-bit address space into an 8 KiB video window, one 16-byte block at a time. A CPU sets it up through five byte registers on an 8-bit bus. Two of them set the source pointer, two set the destination pointer, and one register both sets the block count and starts the transfer. Once started, the engine reads and writes each byte in turn on a simple memory port until every requested block has been moved.

The source and destination registers are not copied into separate counters. They are the counters themselves. At the end of a transfer they hold the address of the block that comes after the last one moved. Software can therefore start another transfer right away, with no rewrite, and it will continue where the first one stopped. It only needs to rewrite the byte it actually wants to change.

Top module: `vdma_engine`

## Requirements
- R1: After reset, busy is low, neither memory request is active, and a read of offset 0x55 returns 0xFF.
- R2: Offsets 0x51 to 0x54 are write-only and always read as 0xFF, both idle and after transfers.
- R3: A write to offset 0x55 starts a transfer of (bits 6:0 + 1) blocks of 16 bytes, so 1 to 128 blocks. Bit 7 of that write is ignored. Busy is high from the cycle after the write.
- R4: Each byte takes two cycles. First a read cycle: mem_rd_req is high and mem_addr holds the source address. Then a write cycle: mem_wr_req is high, mem_addr holds the destination address, and mem_wdata equals the mem_rdata returned one cycle after the read request. Within a block, bytes go in ascending offset order 0 to 15, and source and destination use the same offset.
- R5: The register layout is: 0x51 source high byte, 0x52 source low byte, 0x53 destination high byte, 0x54 destination low byte. Bits 3:0 of a write to 0x52 or 0x54 are ignored, so both pointers always start on a 16-byte boundary.
- R6: Bits 7:5 of a write to 0x53 are ignored. Every destination address is 0x8000 plus a 13-bit offset. Moving from block 0x9FF0 to the next block wraps to 0x8000.
- R7: While a transfer runs, offset 0x55 reads with bit 7 clear and bits 6:0 equal to the number of blocks still to finish minus one. This value drops by one after each completed block.
- R8: Busy falls right after the write cycle of the last byte. From then on, offset 0x55 reads 0xFF.
- R9: At the end of a transfer, each pointer has advanced by 0x10 for every block moved. A new start with no register writes continues from those values.
- R10: A write to one byte of a pointer changes only that byte. The other byte keeps its current value, which may already have advanced.
- R11: Register writes are ignored while busy. Neither the running transfer nor the pointers left afterwards are affected.
- R12: A transfer of N blocks keeps busy high for exactly 32*N cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | Write qualifier for bus_sel |
| bus_addr | input | 8 | Register offset |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Register read data, decoded from bus_addr |
| mem_rd_req | output | 1 | Byte read request |
| mem_wr_req | output | 1 | Byte write request |
| mem_addr | output | 16 | Memory byte address |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, valid the cycle after mem_rd_req |
| busy | output | 1 | Transfer in progress |

## Verification
A pointer that advances wrongly or loses an update shows up on mem_addr during the next read or write cycle. That error may only become visible in a later, chained transfer, which is why the tests run transfers back to back without rewriting the registers. A wrong block counter shows up on the 0x55 readback at the start of the next block. It also shows up on the cycle where busy falls, which is checked to the exact cycle. A wrong byte sequence is caught within two cycles, because each read address is compared with the write that follows it.

// File: rtl/vdma_pkg.sv
package vdma_pkg;
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_RD   = 2'd1,
        PH_WR   = 2'd2
    } phase_e;
endpackage

// File: rtl/vdma_ptr.sv
// Block-granular pointer: byte-wise loadable, advances one block per pulse.
module vdma_ptr #(
    parameter int BLK_W  = 12,
    parameter int DATA_W = 8,
    parameter int BYTE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_hi,
    input  logic              wr_lo,
    input  logic [DATA_W-1:0] wdata,
    input  logic              adv,
    output logic [BLK_W-1:0]  blk
);
    localparam int LO_W = DATA_W - BYTE_W;
    localparam int HI_W = BLK_W - LO_W;

    logic [BLK_W-1:0] blk_d, blk_q;

    always_comb begin
        blk_d = blk_q;
        if (wr_hi) blk_d[BLK_W-1:LO_W] = wdata[HI_W-1:0];
        if (wr_lo) blk_d[LO_W-1:0]     = wdata[DATA_W-1:BYTE_W];
        if (adv)   blk_d               = blk_q + BLK_W'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) blk_q <= '0;
        else        blk_q <= blk_d;
    end

    assign blk = blk_q;
endmodule

// File: rtl/vdma_seq.sv
// Transfer sequencer: read/write alternation, byte index, blocks left.
module vdma_seq #(
    parameter int CNT_W  = 7,
    parameter int BYTE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [CNT_W-1:0]  cnt_in,
    output logic              rd_req,
    output logic              wr_req,
    output logic [BYTE_W-1:0] byte_idx,
    output logic              blk_done,
    output logic              busy,
    output logic [CNT_W-1:0]  left
);
    import vdma_pkg::*;

    typedef struct packed {
        phase_e            ph;
        logic [BYTE_W-1:0] idx;
        logic [CNT_W-1:0]  left;
    } seq_t;

    seq_t s_d, s_q;
    logic done_d;

    always_comb begin
        s_d    = s_q;
        done_d = 1'b0;
        case (s_q.ph)
            PH_IDLE: begin
                if (start) begin
                    s_d.ph   = PH_RD;
                    s_d.idx  = '0;
                    s_d.left = cnt_in;
                end
            end
            PH_RD: s_d.ph = PH_WR;
            PH_WR: begin
                if (s_q.idx == {BYTE_W{1'b1}}) begin
                    done_d  = 1'b1;
                    s_d.idx = '0;
                    if (s_q.left == '0) begin
                        s_d.ph = PH_IDLE;
                    end else begin
                        s_d.ph   = PH_RD;
                        s_d.left = s_q.left - CNT_W'(1);
                    end
                end else begin
                    s_d.ph  = PH_RD;
                    s_d.idx = s_q.idx + BYTE_W'(1);
                end
            end
            default: s_d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.ph   <= PH_IDLE;
            s_q.idx  <= '0;
            s_q.left <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign rd_req   = (s_q.ph == PH_RD);
    assign wr_req   = (s_q.ph == PH_WR);
    assign busy     = (s_q.ph != PH_IDLE);
    assign byte_idx = s_q.idx;
    assign left     = s_q.left;
    assign blk_done = done_d;
endmodule

// File: rtl/vdma_engine.sv
module vdma_engine #(
    parameter int              DATA_W   = 8,
    parameter int              ADDR_W   = 16,
    parameter int              WIN_W    = 13,
    parameter int              BYTE_W   = 4,
    parameter int              CNT_W    = 7,
    parameter int              REG_AW   = 8,
    parameter logic [REG_AW-1:0] REG_BASE = 8'h51,
    parameter logic [ADDR_W-WIN_W-1:0] WIN_BASE = 3'b100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [REG_AW-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              mem_rd_req,
    output logic              mem_wr_req,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              busy
);
    localparam int SRC_BLK_W = ADDR_W - BYTE_W;
    localparam int DST_BLK_W = WIN_W - BYTE_W;
    localparam int NREG      = 5;
    localparam int R_SRC_HI  = 0;
    localparam int R_SRC_LO  = 1;
    localparam int R_DST_HI  = 2;
    localparam int R_DST_LO  = 3;
    localparam int R_CTL     = 4;

    logic [NREG-1:0]      wr_stb;
    logic [SRC_BLK_W-1:0] src_blk;
    logic [DST_BLK_W-1:0] dst_blk;
    logic [BYTE_W-1:0]    byte_idx;
    logic [CNT_W-1:0]     left;
    logic                 blk_done;
    logic                 rd_req, wr_req, run;

    for (genvar g = 0; g < NREG; g++) begin : g_dec
        assign wr_stb[g] = bus_sel & bus_wr & ~run &
                           (bus_addr == REG_BASE + REG_AW'(g));
    end

    vdma_ptr #(.BLK_W(SRC_BLK_W), .DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_src (
        .clk(clk), .rst_n(rst_n),
        .wr_hi(wr_stb[R_SRC_HI]), .wr_lo(wr_stb[R_SRC_LO]),
        .wdata(bus_wdata), .adv(blk_done), .blk(src_blk)
    );

    vdma_ptr #(.BLK_W(DST_BLK_W), .DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_dst (
        .clk(clk), .rst_n(rst_n),
        .wr_hi(wr_stb[R_DST_HI]), .wr_lo(wr_stb[R_DST_LO]),
        .wdata(bus_wdata), .adv(blk_done), .blk(dst_blk)
    );

    vdma_seq #(.CNT_W(CNT_W), .BYTE_W(BYTE_W)) u_seq (
        .clk(clk), .rst_n(rst_n),
        .start(wr_stb[R_CTL]), .cnt_in(bus_wdata[CNT_W-1:0]),
        .rd_req(rd_req), .wr_req(wr_req), .byte_idx(byte_idx),
        .blk_done(blk_done), .busy(run), .left(left)
    );

    always_comb begin
        bus_rdata = '1;
        if (bus_addr == REG_BASE + REG_AW'(R_CTL) && run)
            bus_rdata = DATA_W'({1'b0, left});
    end

    always_comb begin
        mem_addr = {src_blk, byte_idx};
        if (wr_req) mem_addr = {WIN_BASE, dst_blk, byte_idx};
    end

    assign mem_rd_req = rd_req;
    assign mem_wr_req = wr_req;
    assign mem_wdata  = mem_rdata;
    assign busy       = run;
endmodule

// File: rtl/vdma_engine_chk.sv
module vdma_engine_chk #(
    parameter int ADDR_W = 16,
    parameter int WIN_W  = 13,
    parameter int BYTE_W = 4,
    parameter int DATA_W = 8,
    parameter int REG_AW = 8,
    parameter logic [REG_AW-1:0] CTL_OFS = 8'h55,
    parameter logic [ADDR_W-WIN_W-1:0] WIN_BASE = 3'b100
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              mem_rd_req,
    input logic              mem_wr_req,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [REG_AW-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_rdata
);
    // R4
    excl_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mem_rd_req, mem_wr_req}));

    // R4
    rd_then_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_req |=> mem_wr_req);

    // R4
    same_ofs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_req |-> mem_addr[BYTE_W-1:0] == $past(mem_addr[BYTE_W-1:0]));

    // R6
    win_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_req |-> mem_addr[ADDR_W-1:WIN_W] == WIN_BASE);

    // R8
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_rd_req && !mem_wr_req);

    // R7
    run_stat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && bus_addr == CTL_OFS) |-> !bus_rdata[DATA_W-1]);
endmodule

bind vdma_engine vdma_engine_chk #(
    .ADDR_W(ADDR_W), .WIN_W(WIN_W), .BYTE_W(BYTE_W), .DATA_W(DATA_W),
    .REG_AW(REG_AW), .CTL_OFS(REG_BASE + REG_AW'(4)), .WIN_BASE(WIN_BASE)
) u_chk (
    .clk(clk), .rst_n(rst_n), .busy(busy), .mem_rd_req(mem_rd_req),
    .mem_wr_req(mem_wr_req), .mem_addr(mem_addr), .bus_addr(bus_addr),
    .bus_rdata(bus_rdata)
);

// File: tb/vdma_engine_test.sv
module vdma_engine_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [7:0]  bus_addr = 8'h55, bus_wdata = 8'h00;
    logic [7:0]  bus_rdata;
    logic        mem_rd_req, mem_wr_req, busy;
    logic [15:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic [7:0]  mem_rdata = 8'h00;

    int total = 0;
    int bad   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    vdma_engine uut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .mem_rd_req(mem_rd_req), .mem_wr_req(mem_wr_req), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .busy(busy)
    );

    function automatic logic [7:0] pat(input logic [15:0] a);
        return a[7:0] ^ (a[15:8] + 8'h5A);
    endfunction

    always @(posedge clk) if (mem_rd_req) mem_rdata <= pat(mem_addr);

    task automatic chk(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic reg_wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = 8'h55;
    endtask

    // Starts at the first sample after the start write; checks every cycle.
    task automatic xfer(input string tag, input logic [15:0] src,
                        input logic [15:0] dst, input int n, input bit poke);
        logic [15:0] es, ed;
        for (int b = 0; b < n; b++) begin
            for (int i = 0; i < 16; i++) begin
                es = src + 16'(b * 16 + i);
                ed = 16'h8000 | {3'b000, 13'(dst[12:0] + 13'(b * 16 + i))};
                if (i == 0)
                    chk(bus_rdata == 8'(n - 1 - b), {tag, " R7 status"},
                        bus_rdata, 8'(n - 1 - b));
                chk(mem_rd_req && !mem_wr_req && busy, {tag, " R4 rd phase"},
                    {mem_rd_req, mem_wr_req, busy}, 3'b101);
                chk(mem_addr == es, {tag, " R4 src addr"}, mem_addr, es);
                if (poke && b == 0 && (i == 5 || i == 9)) begin
                    bus_sel = 1'b1; bus_wr = 1'b1;
                    bus_addr = (i == 5) ? 8'h52 : 8'h55;
                    bus_wdata = (i == 5) ? 8'h00 : 8'h05;
                end
                @(negedge clk);
                bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = 8'h55;
                chk(mem_wr_req && !mem_rd_req && busy, {tag, " R4 wr phase"},
                    {mem_rd_req, mem_wr_req, busy}, 3'b011);
                chk(mem_addr == ed, {tag, " R6 dst addr"}, mem_addr, ed);
                chk(mem_wdata == pat(es), {tag, " R4 data"}, mem_wdata, pat(es));
                @(negedge clk);
            end
        end
        chk(!busy && !mem_rd_req && !mem_wr_req, {tag, " R12 busy end"},
            {busy, mem_rd_req, mem_wr_req}, 3'b000);
        chk(bus_rdata == 8'hFF, {tag, " R8 status done"}, bus_rdata, 8'hFF);
    endtask

    task automatic t_reset();
        chk(!busy && !mem_rd_req && !mem_wr_req, "R1 idle outputs",
            {busy, mem_rd_req, mem_wr_req}, 3'b000);
        chk(bus_rdata == 8'hFF, "R1 status", bus_rdata, 8'hFF);
        for (int a = 8'h51; a <= 8'h54; a++) begin
            bus_addr = 8'(a); #1;
            chk(bus_rdata == 8'hFF, "R2 write-only read", bus_rdata, 8'hFF);
        end
        bus_addr = 8'h55;
    endtask

    task automatic t_basic();
        reg_wr(8'h51, 8'h12); reg_wr(8'h52, 8'h34);
        reg_wr(8'h53, 8'h80); reg_wr(8'h54, 8'h0F);
        reg_wr(8'h55, 8'h80);
        xfer("R3 R5 basic", 16'h1230, 16'h8000, 1, 1'b0);
    endtask

    task automatic t_chain();
        reg_wr(8'h55, 8'h01);
        xfer("R9 chain", 16'h1240, 16'h8010, 2, 1'b0);
    endtask

    task automatic t_partial();
        reg_wr(8'h52, 8'h00);
        reg_wr(8'h53, 8'hFF);
        reg_wr(8'h54, 8'hF5);
        reg_wr(8'h55, 8'h01);
        xfer("R10 R6 partial wrap", 16'h1200, 16'h9FF0, 2, 1'b0);
    endtask

    task automatic t_busy_ignore();
        reg_wr(8'h55, 8'h00);
        xfer("R11 poke", 16'h1220, 16'h8010, 1, 1'b1);
        reg_wr(8'h55, 8'h00);
        xfer("R11 after", 16'h1230, 16'h8020, 1, 1'b0);
    endtask

    task automatic t_max();
        reg_wr(8'h51, 8'h40); reg_wr(8'h52, 8'h00);
        reg_wr(8'h53, 8'h00); reg_wr(8'h54, 8'h00);
        reg_wr(8'h55, 8'h7F);
        xfer("R3 R12 max", 16'h4000, 16'h8000, 128, 1'b0);
        for (int a = 8'h51; a <= 8'h54; a++) begin
            bus_addr = 8'(a); #1;
            chk(bus_rdata == 8'hFF, "R2 read after run", bus_rdata, 8'hFF);
        end
        bus_addr = 8'h55;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_chain();
        t_partial();
        t_busy_ignore();
        t_max();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog act=running exp=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule